// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move bytes between itself and a local packet memory through one data port. The host loads a 16-bit remote address and a 16-bit remote byte count with byte-wide register writes. After that, each access to the data port reads or writes memory at the current address. The address then advances by the width of the access and the count drops by the same amount. When the count runs out, a completion status bit is set and can raise an interrupt.

Accesses are 8-bit or 16-bit, chosen by a configuration bit, or 32-bit when the host asks for a wide access. Multi-byte accesses are little-endian. Memory is reached over a byte-lane interface: lane i carries the byte at the base address plus i. The address wraps inside a ring that is bounded by start and stop page registers. Only a low window and a packet-memory window are backed by storage. Reads outside them return all ones, and writes outside them never reach memory.

Every port access completes in one clock and has no back-pressure. The memory answers reads combinationally in the same cycle.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the remote address and count are 0, the status is 0x80, the mask is 0, the 16-bit mode is off and irq is low.
- R2: The register select codes are 1 and 2 for the address low and high bytes, and 3 and 4 for the count low and high bytes. Each write replaces only its own byte of the 16-bit value, and the change is visible the cycle after the write.
- R3: The access size is 4 bytes when port_wide is high. Otherwise it is 2 bytes when bit 0 of the configuration register (select 7) is set, and 1 byte when it is clear. After each accepted access the address grows by the access size.
- R4: If the advanced address equals the stop page (select 6) times 256, the address is reloaded with the start page (select 5) times 256.
- R5: If the count is at most the access size, an accepted access sets the count to 0 and sets status bit 6. Otherwise the access size is subtracted from the count.
- R6: A port write while the count is 0 is ignored: there is no memory request, and address, count and status stay unchanged. A port read while the count is 0 still runs and still advances the address.
- R7: A command write (select 0) with bit 0 clear clears status bit 7. If that command also has bit 3 or bit 4 set while the count is 0, it sets status bit 6 at once. A command with bit 0 set changes neither bit.
- R8: 16-bit and 32-bit accesses force address bit 0 to 0. Lane i of port_wdata, port_rdata and mem_rdata is bits 8i+7..8i and carries the byte at mem_addr plus i. mem_be enables the lowest size lanes.
- R9: An access is valid when the even-adjusted address is below LOW_WIN, or when it is at least WIN_LO and its last byte lies below WIN_HI. An invalid access makes no memory request, and each active read lane returns 0xFF. Inactive read lanes return 0.
- R10: irq is high when any of status bits 0 to 6 is set together with the same bit of the mask register (select 8). Writing the status register (select 9) clears each of bits 0 to 6 written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select code |
| reg_wdata | input | 8 | Register write byte |
| port_valid | input | 1 | Data port access this cycle |
| port_write | input | 1 | Data port access is a write |
| port_wide | input | 1 | Data port access is 32-bit |
| port_wdata | input | 32 | Data port write data, little-endian lanes |
| port_rdata | output | 32 | Data port read data, same cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address of lane 0 |
| mem_be | output | 4 | Memory lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| dma_addr | output | 16 | Current remote address |
| dma_count | output | 16 | Remaining remote byte count |
| status | output | 8 | Status bits |
| irq | output | 1 | Interrupt request |

## Verification
The data port is driven with byte, word and 32-bit accesses, both reads and writes, at odd and even addresses. Odd addresses separate the even-forcing of wide accesses from plain byte addressing. Counts are chosen below, equal to and above the access size, so the bench can tell a count that reaches zero from a normal decrement. Addresses are placed at both edges of each valid window and one access short of the stop page, which separates the wrap from a plain increment and a valid access from an invalid one. Random register writes mixed into the traffic check that half-register updates, command completion and status clears interact correctly with the port.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int ADDR_W = 16;
    localparam int PG_W   = 8;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;
    localparam int ST_W   = 8;
    localparam int SZ_W   = 3;

    localparam int ST_DONE  = 6;
    localparam int ST_RST   = 7;
    localparam int CMD_HALT = 0;
    localparam int CMD_RD   = 3;
    localparam int CMD_WR   = 4;
    localparam int CFG_WORD = 0;

    localparam logic [ST_W-1:0] ST_RESET_VAL = 8'h80;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD     = 4'd0,
        SEL_ADDR_LO = 4'd1,
        SEL_ADDR_HI = 4'd2,
        SEL_CNT_LO  = 4'd3,
        SEL_CNT_HI  = 4'd4,
        SEL_START   = 4'd5,
        SEL_STOP    = 4'd6,
        SEL_CFG     = 4'd7,
        SEL_MASK    = 4'd8,
        SEL_STATUS  = 4'd9
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] count;
        logic [PG_W-1:0]   start_pg;
        logic [PG_W-1:0]   stop_pg;
        logic              cfg_word;
        logic [ST_W-2:0]   mask;
        logic [ST_W-1:0]   status;
    } rdma_regs_t;
endpackage

// File: rtl/rdma_step.sv
module rdma_step
    import rdma_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int PW  = PG_W,
    parameter int SW  = SZ_W
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] count,
    input  logic [SW-1:0] size,
    input  logic [PW-1:0] start_pg,
    input  logic [PW-1:0] stop_pg,
    output logic [AW-1:0] nxt_addr,
    output logic [AW-1:0] nxt_count,
    output logic          done
);
    localparam int OFF_W = AW - PW;

    logic [AW-1:0] size_ext;
    logic [AW-1:0] sum;
    logic [AW-1:0] stop_a;
    logic [AW-1:0] start_a;

    always_comb begin
        size_ext  = AW'(size);
        sum       = addr + size_ext;
        stop_a    = {stop_pg, {OFF_W{1'b0}}};
        start_a   = {start_pg, {OFF_W{1'b0}}};
        nxt_addr  = (sum == stop_a) ? start_a : sum;
        done      = (count <= size_ext);
        nxt_count = done ? '0 : (count - size_ext);
    end
endmodule

// File: rtl/rdma_lane_map.sv
module rdma_lane_map
    import rdma_pkg::*;
#(
    parameter int BYTES   = 4,
    parameter int AW      = ADDR_W,
    parameter int SW      = SZ_W,
    parameter int LOW_WIN = 32,
    parameter int WIN_LO  = 32'h4000,
    parameter int WIN_HI  = 32'h8000
) (
    input  logic [AW-1:0]         addr,
    input  logic [SW-1:0]         size,
    input  logic                  access_en,
    input  logic [BYTES*BYTE_W-1:0] mem_rdata,
    output logic [AW-1:0]         eff_addr,
    output logic                  in_range,
    output logic [BYTES-1:0]      lane_be,
    output logic [BYTES*BYTE_W-1:0] rdata
);
    logic [AW:0] span_end;

    always_comb begin
        eff_addr = (size > SW'(1)) ? {addr[AW-1:1], 1'b0} : addr;
        span_end = {1'b0, eff_addr} + (AW+1)'(size);
        in_range = (eff_addr < AW'(LOW_WIN)) ||
                   ((eff_addr >= AW'(WIN_LO)) && (span_end <= (AW+1)'(WIN_HI)));
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic lane_on;
        always_comb begin
            lane_on    = (SW'(g) < size);
            lane_be[g] = access_en && in_range && lane_on;
            if (!lane_on)
                rdata[g*BYTE_W +: BYTE_W] = '0;
            else if (in_range)
                rdata[g*BYTE_W +: BYTE_W] = mem_rdata[g*BYTE_W +: BYTE_W];
            else
                rdata[g*BYTE_W +: BYTE_W] = '1;
        end
    end
endmodule

// File: rtl/rdma_regfile.sv
module rdma_regfile
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              step_fire,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [ADDR_W-1:0] nxt_count,
    input  logic              step_done,
    output rdma_regs_t        regs
);
    localparam int OFF_W = ADDR_W - PG_W;

    rdma_regs_t r_d, r_q;
    reg_sel_e   sel;

    always_comb begin
        sel = reg_sel_e'(reg_sel);
        r_d = r_q;
        if (reg_wr) begin
            case (sel)
                SEL_CMD: begin
                    if (!reg_wdata[CMD_HALT]) begin
                        r_d.status[ST_RST] = 1'b0;
                        if ((reg_wdata[CMD_RD] || reg_wdata[CMD_WR]) && (r_q.count == '0))
                            r_d.status[ST_DONE] = 1'b1;
                    end
                end
                SEL_ADDR_LO: r_d.addr[BYTE_W-1:0]         = reg_wdata;
                SEL_ADDR_HI: r_d.addr[ADDR_W-1:BYTE_W]    = reg_wdata;
                SEL_CNT_LO:  r_d.count[BYTE_W-1:0]        = reg_wdata;
                SEL_CNT_HI:  r_d.count[ADDR_W-1:BYTE_W]   = reg_wdata;
                SEL_START:   r_d.start_pg                 = reg_wdata;
                SEL_STOP:    r_d.stop_pg                  = reg_wdata;
                SEL_CFG:     r_d.cfg_word                 = reg_wdata[CFG_WORD];
                SEL_MASK:    r_d.mask                     = reg_wdata[ST_W-2:0];
                SEL_STATUS:  r_d.status[ST_W-2:0]         = r_q.status[ST_W-2:0] & ~reg_wdata[ST_W-2:0];
                default: ;
            endcase
        end
        if (step_fire) begin
            r_d.addr  = nxt_addr;
            r_d.count = nxt_count;
            if (step_done)
                r_d.status[ST_DONE] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.status   <= ST_RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;

    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fire && step_done) |=> r_q.status[ST_DONE]);

    // R7
    done_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.status[ST_DONE]) |-> $past(step_fire || reg_wr));

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fire && !reg_wr && (r_q.start_pg != r_q.stop_pg))
            |=> (r_q.addr != {r_q.stop_pg, {OFF_W{1'b0}}}));
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int BYTES   = 4,
    parameter int LOW_WIN = 32,
    parameter int WIN_LO  = 32'h4000,
    parameter int WIN_HI  = 32'h8000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [SEL_W-1:0]        reg_sel,
    input  logic [BYTE_W-1:0]       reg_wdata,
    input  logic                    port_valid,
    input  logic                    port_write,
    input  logic                    port_wide,
    input  logic [BYTES*BYTE_W-1:0] port_wdata,
    output logic [BYTES*BYTE_W-1:0] port_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BYTES-1:0]        mem_be,
    output logic [BYTES*BYTE_W-1:0] mem_wdata,
    input  logic [BYTES*BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0]       dma_addr,
    output logic [ADDR_W-1:0]       dma_count,
    output logic [ST_W-1:0]         status,
    output logic                    irq
);
    rdma_regs_t        regs;
    logic [SZ_W-1:0]   acc_size;
    logic              step_fire;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] nxt_count;
    logic              step_done;
    logic [ADDR_W-1:0] eff_addr;
    logic              in_range;

    always_comb begin
        if (port_wide)
            acc_size = SZ_W'(BYTES);
        else if (regs.cfg_word)
            acc_size = SZ_W'(2);
        else
            acc_size = SZ_W'(1);
        step_fire = port_valid && !(port_write && (regs.count == '0));
    end

    rdma_step i_step (
        .addr      (regs.addr),
        .count     (regs.count),
        .size      (acc_size),
        .start_pg  (regs.start_pg),
        .stop_pg   (regs.stop_pg),
        .nxt_addr  (nxt_addr),
        .nxt_count (nxt_count),
        .done      (step_done)
    );

    rdma_lane_map #(
        .BYTES   (BYTES),
        .LOW_WIN (LOW_WIN),
        .WIN_LO  (WIN_LO),
        .WIN_HI  (WIN_HI)
    ) i_lanes (
        .addr      (regs.addr),
        .size      (acc_size),
        .access_en (step_fire),
        .mem_rdata (mem_rdata),
        .eff_addr  (eff_addr),
        .in_range  (in_range),
        .lane_be   (mem_be),
        .rdata     (port_rdata)
    );

    rdma_regfile i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .step_fire (step_fire),
        .nxt_addr  (nxt_addr),
        .nxt_count (nxt_count),
        .step_done (step_done),
        .regs      (regs)
    );

    always_comb begin
        mem_req   = step_fire && in_range;
        mem_we    = port_write;
        mem_addr  = eff_addr;
        mem_wdata = port_wdata;
        dma_addr  = regs.addr;
        dma_count = regs.count;
        status    = regs.status;
        irq       = |(regs.status[ST_W-2:0] & regs.mask);
    end

    // R6
    ignored_wr_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && port_write && (dma_count == '0)) |-> !mem_req);

    // R6
    ignored_wr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && port_write && (dma_count == '0) && !reg_wr)
            |=> ($stable(dma_addr) && (dma_count == '0) && $stable(status)));

    // R8
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 || mem_be == 4'b1111));

    // R8
    even_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ($countones(mem_be) > 1)) |-> (mem_addr[0] == 1'b0));
endmodule

// File: tb/test_rdma_port_engine.sv
`timescale 1ns/1ps
module test_rdma_port_engine;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        port_valid = 1'b0;
    logic        port_write = 1'b0;
    logic        port_wide = 1'b0;
    logic [31:0] port_wdata = '0;
    logic [31:0] port_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic [15:0] dma_addr, dma_count;
    logic [7:0]  status;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    // bench model state
    logic [15:0] e_addr, e_cnt;
    logic [7:0]  e_start, e_stop, e_st;
    logic [6:0]  e_mask;
    logic        e_word;

    always #(CLK_NS/2) clk = ~clk;

    rdma_port_engine i_rdma_port_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .port_valid(port_valid), .port_write(port_write), .port_wide(port_wide),
        .port_wdata(port_wdata), .port_rdata(port_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dma_addr(dma_addr), .dma_count(dma_count), .status(status), .irq(irq)
    );

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // memory model: lane i returns the byte stored at mem_addr + i
    always_comb begin
        for (int i = 0; i < 4; i++) mem_rdata[i*8 +: 8] = mbyte(mem_addr + 16'(i));
    end

    function automatic bit in_win(input logic [15:0] a, input int sz);
        return (a < 16'd32) || (a >= 16'h4000 && (int'(a) + sz) <= 32'h8000);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " addr"},   32'(dma_addr),  32'(e_addr));
        check({req, " count"},  32'(dma_count), 32'(e_cnt));
        check({req, " status"}, 32'(status),    32'(e_st));
        check({req, " irq"},    32'(irq),       32'(|(e_st[6:0] & e_mask)));
    endtask

    task automatic wr_reg(input logic [3:0] sel, input logic [7:0] d, input string req);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        case (sel)
            4'd0: begin
                if (!d[0]) begin
                    e_st[7] = 1'b0;
                    if ((d[3] || d[4]) && e_cnt == 16'd0) e_st[6] = 1'b1;
                end
            end
            4'd1: e_addr[7:0]  = d;
            4'd2: e_addr[15:8] = d;
            4'd3: e_cnt[7:0]   = d;
            4'd4: e_cnt[15:8]  = d;
            4'd5: e_start      = d;
            4'd6: e_stop       = d;
            4'd7: e_word       = d[0];
            4'd8: e_mask       = d[6:0];
            4'd9: e_st[6:0]    = e_st[6:0] & ~d[6:0];
            default: ;
        endcase
        @(negedge clk);
        reg_wr = 1'b0;
        check_state(req);
    endtask

    task automatic port_op(input bit wr, input bit wide, input logic [31:0] wd, input string req);
        int sz;
        logic [15:0] eff;
        bit ok, fire;
        logic [31:0] exp_rd;
        logic [3:0]  exp_be;
        @(negedge clk);
        port_valid = 1'b1; port_write = wr; port_wide = wide; port_wdata = wd;
        sz   = wide ? 4 : (e_word ? 2 : 1);
        eff  = (sz > 1) ? {e_addr[15:1], 1'b0} : e_addr;
        ok   = in_win(eff, sz);
        fire = !(wr && e_cnt == 16'd0);
        exp_rd = '0;
        exp_be = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < sz) begin
                exp_rd[i*8 +: 8] = ok ? mbyte(eff + 16'(i)) : 8'hFF;
                exp_be[i] = fire && ok;
            end
        end
        #1;
        check({req, " mem_req"}, 32'(mem_req), 32'(fire && ok));
        if (fire && ok) begin
            check({req, " mem_addr"}, 32'(mem_addr), 32'(eff));
            check({req, " mem_be"},   32'(mem_be),   32'(exp_be));
            check({req, " mem_we"},   32'(mem_we),   32'(wr));
            if (wr) check({req, " mem_wdata"}, mem_wdata, wd);
        end
        if (!wr) check({req, " rdata"}, port_rdata, exp_rd);
        if (fire) begin
            e_addr = e_addr + 16'(sz);
            if (e_addr == {e_stop, 8'h00}) e_addr = {e_start, 8'h00};
            if (int'(e_cnt) <= sz) begin
                e_cnt = 16'd0;
                e_st[6] = 1'b1;
            end else begin
                e_cnt = e_cnt - 16'(sz);
            end
        end
        @(negedge clk);
        port_valid = 1'b0; port_write = 1'b0; port_wide = 1'b0;
        check_state(req);
    endtask

    task automatic set16(input logic [3:0] lo_sel, input logic [15:0] v, input string req);
        wr_reg(lo_sel, v[7:0], req);
        wr_reg(lo_sel + 4'd1, v[15:8], req);
    endtask

    initial begin : watchdog
        #(CLK_NS * 200000);
        if (!done_flag) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] a;
        e_addr = '0; e_cnt = '0; e_start = '0; e_stop = '0; e_st = 8'h80; e_mask = '0; e_word = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_state("R1");

        // R7 command handling
        wr_reg(4'd0, 8'h09, "R7 halt cmd keeps bit7");
        wr_reg(4'd0, 8'h22, "R7 run clears bit7");
        wr_reg(4'd0, 8'h0A, "R7 zero count read done");
        wr_reg(4'd9, 8'h40, "R10 status clear");
        wr_reg(4'd0, 8'h11, "R7 halt with write no done");
        wr_reg(4'd0, 8'h12, "R7 zero count write done");
        wr_reg(4'd9, 8'h7F, "R10 status clear all");

        // R2 half updates
        set16(4'd1, 16'h1234, "R2 addr");
        wr_reg(4'd1, 8'h56, "R2 addr low only");
        set16(4'd3, 16'hABCD, "R2 count");
        wr_reg(4'd4, 8'h00, "R2 count high only");

        // R3 / R5 sizes and counts in the packet window
        wr_reg(4'd5, 8'h40, "R4 start");
        wr_reg(4'd6, 8'h42, "R4 stop");
        set16(4'd1, 16'h4000, "R3 addr");
        set16(4'd3, 16'd5, "R5 count");
        port_op(0, 0, 32'h0, "R3 byte read");
        wr_reg(4'd7, 8'h01, "R3 word mode");
        port_op(0, 0, 32'h0, "R8 odd word read");
        port_op(1, 1, 32'hDEADBEEF, "R5 wide write ends count");
        port_op(1, 0, 32'h0000_1111, "R6 write at zero count");
        port_op(0, 0, 32'h0, "R6 read at zero count");

        // R4 wrap
        set16(4'd1, 16'h41FE, "R4 addr");
        set16(4'd3, 16'd10, "R4 count");
        port_op(1, 0, 32'h0000_A55A, "R4 wrap to start");

        // R9 invalid windows
        set16(4'd1, 16'h0100, "R9 addr");
        wr_reg(4'd7, 8'h00, "R9 byte mode");
        port_op(0, 0, 32'h0, "R9 invalid byte read");
        port_op(1, 0, 32'h77, "R9 invalid byte write");
        set16(4'd1, 16'h7FFE, "R9 addr edge");
        port_op(0, 1, 32'h0, "R9 wide read past window");
        set16(4'd1, 16'h001E, "R9 low window");
        port_op(0, 1, 32'h0, "R9 low window wide read");

        // R10 interrupt mask
        wr_reg(4'd8, 8'h40, "R10 mask done");
        wr_reg(4'd9, 8'h40, "R10 clear done");
        wr_reg(4'd8, 8'hFF, "R10 mask all no bit7");

        // random traffic
        for (int it = 0; it < 3000; it++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 60) begin
                port_op($urandom_range(0, 1), ($urandom_range(0, 3) == 0), $urandom, "R3 R5 random port");
            end else if (r < 70) begin
                case ($urandom_range(0, 4))
                    0: a = 16'($urandom_range(0, 40));
                    1: a = 16'h3FF0 + 16'($urandom_range(0, 31));
                    2: a = 16'h7FF0 + 16'($urandom_range(0, 15));
                    3: a = {e_stop, 8'h00} - 16'($urandom_range(1, 8));
                    default: a = 16'h4000 + 16'($urandom_range(0, 16'h0FFF));
                endcase
                wr_reg(4'd1, a[7:0], "R2 random addr");
                wr_reg(4'd2, a[15:8], "R2 random addr");
            end else if (r < 78) begin
                wr_reg(4'($urandom_range(3, 4)), ($urandom_range(0, 1) ? 8'($urandom_range(0, 9)) : 8'h00), "R2 random count");
            end else if (r < 83) begin
                wr_reg(4'd0, 8'($urandom), "R7 random cmd");
            end else if (r < 88) begin
                wr_reg(4'd9, 8'($urandom), "R10 random clear");
            end else if (r < 92) begin
                wr_reg(4'd8, 8'($urandom), "R10 random mask");
            end else if (r < 96) begin
                wr_reg(4'd7, 8'($urandom), "R3 random cfg");
            end else begin
                wr_reg(4'd5, 8'h40 + 8'($urandom_range(0, 2)), "R4 random start");
                wr_reg(4'd6, 8'h41 + 8'($urandom_range(0, 4)), "R4 random stop");
            end
        end

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
    end
endmodule